// File: doc/BRIEF.md
# Channel-to-Bus Write Staging Engine

This engine carries one channel's write job from an internal memory space to an external system bus. The channel hands over three values with its request: the internal source address, the external destination address and a word count. The engine first reads the internal words into a local FIFO. Only then does it ask for the system bus, wait for a grant and push the buffered words out as write beats. When the last beat is accepted, it reports completion to the channel.

Reads and writes never overlap inside one chunk. A job longer than the FIFO is cut into chunks of at most `FIFO_DEPTH` words. Each chunk is filled, arbitrated for and drained in turn. Both addresses step by one word for each word moved.

Top module: `bus_write_stager`

## Requirements
- R1: After reset, and whenever the engine is idle, `req_ready` is 1, while `bus_req`, `bus_valid`, `rd_en` and `done` are 0. A request is taken in the cycle where `req_valid` and `req_ready` are both 1.
- R2: The internal reads of a job use consecutive word addresses, starting at `req_src_addr`, one address per `rd_en` cycle. Each `rd_data` word is taken in the cycle after its `rd_en`. The job issues exactly `req_len` reads.
- R3: No chunk holds more than `FIFO_DEPTH` words. Every read of a chunk is issued before `bus_req` rises for that chunk, and `rd_en` is never 1 while `bus_req` is 1.
- R4: Once a chunk is loaded, `bus_req` rises and stays at 1 until `bus_gnt` is seen. No beat is presented before a grant arrives during the current `bus_req` period.
- R5: Write beats complete on `bus_valid && bus_ready`. Beat k of a job carries address `req_dst_addr + k` and the word read from `req_src_addr + k`. While `bus_ready` is 0, `bus_valid`, `bus_addr` and `bus_data` stay unchanged.
- R6: A job of L words (L > 0) raises `bus_req` exactly ceil(L / `FIFO_DEPTH`) times. `bus_req` drops between chunks.
- R7: `done` is a one-cycle pulse in the cycle after the last beat is accepted. In that same cycle the engine is idle again, with `req_ready` = 1.
- R8: A request with `req_len` = 0 gives `done` in the cycle after acceptance. It issues no read and never raises `bus_req`.
- R9: `req_valid` and the request fields are ignored while a job is in progress (`req_ready` = 0). The running job's beats and its single `done` are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Channel write request |
| req_ready | output | 1 | Engine idle, request accepted this cycle if valid |
| req_src_addr | input | ADDR_W | Internal source word address |
| req_dst_addr | input | ADDR_W | External destination word address |
| req_len | input | LEN_W | Transfer length in words |
| done | output | 1 | One-cycle completion pulse |
| rd_en | output | 1 | Internal read strobe |
| rd_addr | output | ADDR_W | Internal read word address |
| rd_data | input | DATA_W | Internal read data, one cycle after rd_en |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| bus_valid | output | 1 | Write beat valid |
| bus_ready | input | 1 | Write beat accepted |
| bus_addr | output | ADDR_W | Write beat word address |
| bus_data | output | DATA_W | Write beat data |

## Verification
The bench builds the engine with `FIFO_DEPTH` = 4 and `LEN_W` = 8. With a FIFO of only four words, short jobs of 5, 6 and 11 words already split into several chunks. This covers the exact-fill case (4), a partial last chunk, and the restart of the fill phase after a drain, all within a few dozen cycles. Grant delays and a ready pattern that stalls two beats out of three are combined with these lengths, so the hold rule and the chunk boundaries are tested together.

// File: rtl/bws_pkg.sv
package bws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_ARB,
    ST_DRAIN
  } bws_state_e;
endpackage

// File: rtl/bws_fifo.sv
module bws_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              empty
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = store[rd_ptr];
  assign empty = (count == '0);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < CNT_W'(DEPTH)));
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/bws_fill_reader.sv
module bws_fill_reader #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_len,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              fill_done
);
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  issue_left, land_left;
  logic              rd_en_q, land_q;
  logic [ADDR_W-1:0] rd_addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr   <= '0;
      issue_left <= '0;
      land_left  <= '0;
      rd_en_q    <= 1'b0;
      rd_addr_q  <= '0;
      land_q     <= 1'b0;
    end else begin
      land_q <= rd_en_q;
      if (start) begin
        cur_addr   <= start_addr;
        issue_left <= start_len;
        land_left  <= start_len;
        rd_en_q    <= 1'b0;
      end else begin
        if (issue_left != '0) begin
          rd_en_q    <= 1'b1;
          rd_addr_q  <= cur_addr;
          cur_addr   <= cur_addr + 1'b1;
          issue_left <= issue_left - 1'b1;
        end else begin
          rd_en_q <= 1'b0;
        end
        if (land_q) land_left <= land_left - 1'b1;
      end
    end
  end

  assign rd_en     = rd_en_q;
  assign rd_addr   = rd_addr_q;
  assign push      = land_q;
  assign push_data = rd_data;
  assign fill_done = land_q && (land_left == CNT_W'(1));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en_q && $past(rd_en_q)) |-> (rd_addr_q == $past(rd_addr_q) + 1'b1));
  assert_land_expected_R2: assert property (@(posedge clk) disable iff (rst)
    land_q |-> (land_left != '0));
endmodule

// File: rtl/bus_write_stager.sv
module bus_write_stager #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_src_addr,
  input  logic [ADDR_W-1:0] req_dst_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              done,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data
);
  import bws_pkg::*;

  bws_state_e        state;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  remain_q;
  logic              done_q;

  logic              accept, beat, chunk_end, start;
  logic [ADDR_W-1:0] start_addr;
  logic [CNT_W-1:0]  start_len, remain_chunk, req_chunk;
  logic              push, fill_done, fifo_empty;
  logic [DATA_W-1:0] push_data, fifo_head;
  logic [CNT_W-1:0]  fifo_count;

  function automatic logic [CNT_W-1:0] chunk_of(input logic [LEN_W-1:0] n);
    if (n > LEN_W'(FIFO_DEPTH)) return CNT_W'(FIFO_DEPTH);
    else return n[CNT_W-1:0];
  endfunction

  assign req_ready    = (state == ST_IDLE);
  assign accept       = req_valid && req_ready;
  assign bus_req      = (state == ST_ARB) || (state == ST_DRAIN);
  assign bus_valid    = (state == ST_DRAIN) && !fifo_empty;
  assign bus_addr     = dst_q;
  assign bus_data     = fifo_head;
  assign beat         = bus_valid && bus_ready;
  assign chunk_end    = beat && (fifo_count == CNT_W'(1));
  assign req_chunk    = chunk_of(req_len);
  assign remain_chunk = chunk_of(remain_q);
  assign start        = (accept && req_len != '0) || (chunk_end && remain_q != '0);
  assign start_addr   = accept ? req_src_addr : src_q;
  assign start_len    = accept ? req_chunk : remain_chunk;
  assign done         = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      src_q    <= '0;
      dst_q    <= '0;
      remain_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          dst_q <= req_dst_addr;
          if (req_len == '0) begin
            done_q <= 1'b1;
          end else begin
            src_q    <= req_src_addr + ADDR_W'(req_chunk);
            remain_q <= req_len - LEN_W'(req_chunk);
            state    <= ST_FILL;
          end
        end
        ST_FILL: if (fill_done) state <= ST_ARB;
        ST_ARB:  if (bus_gnt) state <= ST_DRAIN;
        ST_DRAIN: begin
          if (beat) dst_q <= dst_q + 1'b1;
          if (chunk_end) begin
            if (remain_q == '0) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              src_q    <= src_q + ADDR_W'(remain_chunk);
              remain_q <= remain_q - LEN_W'(remain_chunk);
              state    <= ST_FILL;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  bws_fill_reader #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_reader (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_addr(start_addr),
    .start_len (start_len),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .push      (push),
    .push_data (push_data),
    .fill_done (fill_done)
  );

  bws_fifo #(
    .DATA_W(DATA_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .push_data(push_data),
    .pop      (beat),
    .head     (fifo_head),
    .count    (fifo_count),
    .empty    (fifo_empty)
  );

  assert_no_read_during_bus_R3: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> !rd_en);
  assert_req_held_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARB && !bus_gnt) |=> bus_req);
  assert_beat_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_data)));
  assert_beat_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_ready) |=> (!bus_valid || bus_addr == $past(bus_addr) + 1'b1));
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (req_ready && !bus_req));
  assert_zero_len_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && req_len == '0) |=> (done && !bus_req && !rd_en));
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && state == ST_FILL) |=> (state != ST_IDLE));
endmodule

// File: tb/test_bus_write_stager.sv
module test_bus_write_stager;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int LW = 8;
  localparam int D  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_src_addr = '0;
  logic [AW-1:0] req_dst_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          done;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data = '0;
  logic          bus_req;
  logic          bus_gnt = 1'b0;
  logic          bus_valid;
  logic          bus_ready = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;

  always #10 clk = ~clk;

  bus_write_stager #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .FIFO_DEPTH(D)) i_bus_write_stager (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_src_addr(req_src_addr), .req_dst_addr(req_dst_addr), .req_len(req_len),
    .done(done), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_addr(bus_addr), .bus_data(bus_data));

  function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
    return {a[15:0] ^ 16'hC3A5, ~a[15:0]};
  endfunction

  // internal memory: one-cycle read latency
  always @(posedge clk) if (rd_en) rd_data <= word_at(rd_addr);

  int checks = 0;
  int errors = 0;
  int gnt_delay = 0;
  int stall_mode = 0;
  int gwait = 0;
  int cyc = 0;

  // bus model, updated just after the edge
  always @(posedge clk) begin
    #1;
    if (!bus_req) begin gwait = 0; bus_gnt = 1'b0; end
    else if (gwait >= gnt_delay) bus_gnt = 1'b1;
    else gwait++;
    bus_ready = (stall_mode == 0) || (cyc % 3 == 0);
  end

  // monitor, sampled at the falling edge
  logic [AW-1:0] exp_src, exp_dst;
  int beats, beat_err, rd_cnt, rd_err, chunk_rd, max_chunk, rd_during_req;
  int req_rises, early_valid, req_drop, hold_err, done_cnt, done_cyc, last_beat_cyc, accept_cyc;
  bit granted, prev_req, prev_valid, prev_ready;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] prev_data;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (req_valid && req_ready) accept_cyc = cyc;
      if (rd_en) begin
        if (rd_addr != exp_src + AW'(rd_cnt)) rd_err++;
        rd_cnt++;
        if (bus_req) rd_during_req++;
        chunk_rd++;
        if (chunk_rd > max_chunk) max_chunk = chunk_rd;
      end
      if (bus_req && !prev_req) req_rises++;
      if (bus_req && bus_gnt) granted = 1'b1;
      if (!bus_req) begin
        if (prev_req) begin
          if (!granted) req_drop++;
          chunk_rd = 0;
        end
        granted = 1'b0;
      end
      if (bus_valid && !granted) early_valid++;
      if (prev_valid && !prev_ready &&
          (!bus_valid || bus_addr != prev_addr || bus_data != prev_data)) hold_err++;
      if (bus_valid && bus_ready) begin
        if (bus_addr != exp_dst + AW'(beats) || bus_data != word_at(exp_src + AW'(beats)))
          beat_err++;
        beats++;
        last_beat_cyc = cyc;
      end
      if (done) begin done_cnt++; done_cyc = cyc; end
    end
    prev_req = bus_req; prev_valid = bus_valid; prev_ready = bus_ready;
    prev_addr = bus_addr; prev_data = bus_data;
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic clear_monitor(input logic [AW-1:0] s, input logic [AW-1:0] d);
    exp_src = s; exp_dst = d;
    beats = 0; beat_err = 0; rd_cnt = 0; rd_err = 0; chunk_rd = 0; max_chunk = 0;
    rd_during_req = 0; req_rises = 0; early_valid = 0; req_drop = 0; hold_err = 0;
    done_cnt = 0; done_cyc = -1; last_beat_cyc = -1; accept_cyc = -1; granted = 1'b0;
  endtask

  task automatic run_job(input logic [AW-1:0] s, input logic [AW-1:0] d, input int len,
                         input int gd, input int stall, input bit poke);
    int guard = 0;
    gnt_delay = gd; stall_mode = stall;
    @(posedge clk); #2;
    clear_monitor(s, d);
    req_src_addr = s; req_dst_addr = d; req_len = LW'(len); req_valid = 1'b1;
    @(posedge clk); #2;
    req_valid = 1'b0;
    while (done_cnt == 0 && guard < 2000) begin
      @(posedge clk); #2;
      guard++;
      if (poke) begin
        req_valid = !req_ready && !done;
        req_src_addr = 32'hDEAD_0000 + AW'(guard);
        req_dst_addr = 32'hBEEF_0000;
        req_len = 8'd3;
      end
    end
    req_valid = 1'b0;
    repeat (4) @(posedge clk);
    #2;
  endtask

  task automatic check_job(input int len, input string name);
    int exp_chunks = (len + D - 1) / D;
    int exp_max = (len < D) ? len : D;
    $display("-- %s len=%0d", name, len);
    chk(rd_cnt == len, "R2 read count", rd_cnt, len);
    chk(rd_err == 0, "R2 read address order", rd_err, 0);
    chk(max_chunk == exp_max, "R3 max chunk size", max_chunk, exp_max);
    chk(rd_during_req == 0, "R3 read while bus requested", rd_during_req, 0);
    chk(early_valid == 0 && req_drop == 0, "R4 grant before beat", early_valid + req_drop, 0);
    chk(beats == len, "R5 beat count", beats, len);
    chk(beat_err == 0, "R5 beat address/data", beat_err, 0);
    chk(hold_err == 0, "R5 hold under stall", hold_err, 0);
    chk(req_rises == exp_chunks, "R6 bus request periods", req_rises, exp_chunks);
    chk(done_cnt == 1, "R7 single done", done_cnt, 1);
    chk(done_cyc == last_beat_cyc + 1, "R7 done timing", done_cyc, last_beat_cyc + 1);
    chk(req_ready == 1'b1, "R7 idle after done", req_ready, 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready && !bus_req && !bus_valid && !rd_en && !done, "R1 reset state",
        {req_ready, bus_req, bus_valid, rd_en, done}, 5'b10000);
  endtask

  task automatic t_single;
    run_job(32'h100, 32'h8000, 1, 0, 0, 0);
    chk(accept_cyc > 0, "R1 request accepted", accept_cyc, 1);
    check_job(1, "single word");
  endtask

  task automatic t_exact_fill;
    run_job(32'h200, 32'h9000, D, 2, 0, 0);
    check_job(D, "exact fill");
  endtask

  task automatic t_partial_chunks;
    run_job(32'h300, 32'hA000, 5, 1, 1, 0);
    check_job(5, "partial last chunk, stalled");
  endtask

  task automatic t_long;
    run_job(32'h4F0, 32'hB010, 11, 3, 1, 0);
    check_job(11, "long job, slow grant");
  endtask

  task automatic t_zero;
    run_job(32'h600, 32'hC000, 0, 0, 0, 0);
    chk(done_cnt == 1, "R8 zero length done", done_cnt, 1);
    chk(done_cyc == accept_cyc + 1, "R8 zero length timing", done_cyc, accept_cyc + 1);
    chk(rd_cnt == 0 && req_rises == 0, "R8 no read, no bus", rd_cnt + req_rises, 0);
  endtask

  task automatic t_busy_poke;
    run_job(32'h700, 32'hD000, 6, 1, 1, 1);
    check_job(6, "R9 requests while busy");
    chk(beat_err == 0 && done_cnt == 1, "R9 busy request ignored", beat_err + done_cnt, 1);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_monitor('0, '0);
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    t_reset();
    t_single();
    t_exact_fill();
    t_partial_chunks();
    t_long();
    t_zero();
    t_busy_poke();
    t_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule